// File: doc/BRIEF.md
# Parallel LCD Write-Cycle Sequencer

This block performs single write transfers on an 8080-style parallel panel bus. A client offers a request made of a data word and a flag that marks the word as a command or as pixel data. The offer uses a valid/ready handshake. Once accepted, the block steps through four timed phases:

- The register-select line settles on its own.
- Chip select goes low.
- The write strobe pulses low.
- Chip select is held low for a tail after the strobe rises.

After the tail, chip select returns high.

Each phase length comes from its own 4-bit timing input. The input encodes the phase length in clock cycles minus one, so a phase lasts 1 to 16 cycles. The block samples all four inputs when it accepts a request, so changes made during a transfer apply only to the next one. The package holds suggested start-up settings: setup 0, select lead 0, strobe 1, tail 0.

Top module: `lcd_wr_seq`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `lcd_cs_n`=1, `lcd_wr_n`=1, `lcd_dc`=0, `lcd_data`=0, `req_ready`=1, `busy`=0, `done`=0.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. From the next cycle, `lcd_dc` shows the request's flag (1 = pixel data, 0 = command). `lcd_cs_n` then stays high for `cfg_addr_lead`+1 cycles.
- R3: After `lcd_cs_n` falls, `lcd_wr_n` stays high for `cfg_sel_lead`+1 cycles before it falls.
- R4: `lcd_wr_n` stays low for exactly `cfg_strobe_len`+1 cycles. `lcd_data` carries the accepted word from the first cycle of the strobe.
- R5: After `lcd_wr_n` rises, `lcd_cs_n` stays low for a further `cfg_sel_tail`+1 cycles, then rises.
- R6: `lcd_wr_n` is never low while `lcd_cs_n` is high.
- R7: `lcd_data` does not change from the first strobe cycle through the cycle in which `lcd_cs_n` rises.
- R8: `req_ready` is 0 and `busy` is 1 from the cycle after acceptance until `lcd_cs_n` rises. A `req_valid` offered in that time is not taken and does not alter the bus.
- R9: `done` is high for exactly one cycle: the cycle in which `lcd_cs_n` returns high at the end of a transfer.
- R10: The timing inputs are sampled at acceptance. Changing them during a transfer does not alter that transfer's phase lengths.
- R11: A request accepted in the `done` cycle starts a new transfer with its own full address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer (pixel) clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Write request offered |
| req_ready | output | 1 | Block idle and able to take a request |
| req_is_data | input | 1 | 1 = pixel data, 0 = command |
| req_data | input | DATA_W | Word to write |
| cfg_addr_lead | input | TIME_W | Address-to-select length minus one |
| cfg_sel_lead | input | TIME_W | Select-to-strobe length minus one |
| cfg_strobe_len | input | TIME_W | Strobe length minus one |
| cfg_sel_tail | input | TIME_W | Strobe-to-deselect length minus one |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| lcd_cs_n | output | 1 | Chip select, active low |
| lcd_wr_n | output | 1 | Write strobe, active low |
| lcd_dc | output | 1 | Command/data select |
| lcd_data | output | DATA_W | Parallel data bus |

## Verification
The bench runs the following timing settings:

- The suggested defaults.
- All zeros, which gives the shortest cycle and shows that every phase still lasts one cycle.
- All fifteens, which checks the counter's top value.
- Mixed and lopsided values, which expose any swap of one phase's field for another.

Three further patterns target specific behaviour:

- Changing the timing inputs in the middle of a transfer separates sampled timing from live timing.
- Requests issued back-to-back in the `done` cycle show that each transfer restarts at the address phase.
- A request offered while busy, carrying a different word, shows that the handshake blocks it.

The bench also toggles the command/data flag between transfers, which catches a stale `lcd_dc`.

// File: rtl/lcd_wr_pkg.sv
package lcd_wr_pkg;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_ADDR   = 3'd1,
      ST_SEL    = 3'd2,
      ST_STROBE = 3'd3,
      ST_TAIL   = 3'd4
   } seq_state_e;

   localparam int unsigned TIME_W_DEF      = 4;
   localparam int unsigned DEF_ADDR_LEAD   = 0;
   localparam int unsigned DEF_SEL_LEAD    = 0;
   localparam int unsigned DEF_STROBE_LEN  = 1;
   localparam int unsigned DEF_SEL_TAIL    = 0;

endpackage

// File: rtl/lcd_wr_timer.sv
module lcd_wr_timer #(
   parameter int unsigned TIME_W = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic [TIME_W-1:0] load_val,
   output logic              expired
);
   logic [TIME_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);

   p_count_down_r4: assert property (@(posedge clk) disable iff (rst)
      (!load && !expired) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/lcd_wr_fsm.sv
module lcd_wr_fsm
   import lcd_wr_pkg::*;
#(
   parameter int unsigned TIME_W = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              accept,
   input  logic              tmr_expired,
   input  logic [TIME_W-1:0] addr_lead,
   input  logic [TIME_W-1:0] sel_lead_q,
   input  logic [TIME_W-1:0] strobe_len_q,
   input  logic [TIME_W-1:0] sel_tail_q,
   output seq_state_e        state,
   output seq_state_e        state_nxt,
   output logic              tmr_load,
   output logic [TIME_W-1:0] tmr_val
);
   seq_state_e state_q;

   always_comb begin
      state_nxt = state_q;
      tmr_load  = 1'b0;
      tmr_val   = '0;
      unique case (state_q)
         ST_IDLE: if (accept) begin
            state_nxt = ST_ADDR;
            tmr_load  = 1'b1;
            tmr_val   = addr_lead;
         end
         ST_ADDR: if (tmr_expired) begin
            state_nxt = ST_SEL;
            tmr_load  = 1'b1;
            tmr_val   = sel_lead_q;
         end
         ST_SEL: if (tmr_expired) begin
            state_nxt = ST_STROBE;
            tmr_load  = 1'b1;
            tmr_val   = strobe_len_q;
         end
         ST_STROBE: if (tmr_expired) begin
            state_nxt = ST_TAIL;
            tmr_load  = 1'b1;
            tmr_val   = sel_tail_q;
         end
         ST_TAIL: if (tmr_expired) state_nxt = ST_IDLE;
         default: state_nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) state_q <= ST_IDLE;
      else     state_q <= state_nxt;
   end

   assign state = state_q;

   p_phase_order_r11: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_IDLE && state_nxt != ST_IDLE) |-> (state_nxt == ST_ADDR));
endmodule

// File: rtl/lcd_wr_outreg.sv
module lcd_wr_outreg
   import lcd_wr_pkg::*;
#(
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  seq_state_e        state,
   input  seq_state_e        state_nxt,
   input  logic              accept,
   input  logic              req_is_data,
   input  logic [DATA_W-1:0] word_q,
   output logic              cs_n,
   output logic              wr_n,
   output logic              dc,
   output logic [DATA_W-1:0] data,
   output logic              done
);
   logic sel_nxt;

   assign sel_nxt = (state_nxt == ST_SEL) || (state_nxt == ST_STROBE) ||
                    (state_nxt == ST_TAIL);

   always_ff @(posedge clk) begin
      if (rst) begin
         cs_n <= 1'b1;
         wr_n <= 1'b1;
         dc   <= 1'b0;
         data <= '0;
         done <= 1'b0;
      end else begin
         cs_n <= !sel_nxt;
         wr_n <= !(state_nxt == ST_STROBE);
         done <= (state == ST_TAIL) && (state_nxt == ST_IDLE);
         if (accept)
            dc <= req_is_data;
         if (state_nxt == ST_STROBE && state != ST_STROBE)
            data <= word_q;
      end
   end

   p_strobe_in_select_r6: assert property (@(posedge clk) disable iff (rst)
      !wr_n |-> !cs_n);
   p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);
   p_done_on_deselect_r9: assert property (@(posedge clk) disable iff (rst)
      $rose(cs_n) |-> done);
   p_sel_before_strobe_r3: assert property (@(posedge clk) disable iff (rst)
      $fell(wr_n) |-> $past(!cs_n));
   p_data_steady_r7: assert property (@(posedge clk) disable iff (rst)
      ($past(!cs_n) && !$fell(wr_n)) |-> $stable(data));
endmodule

// File: rtl/lcd_wr_seq.sv
module lcd_wr_seq
   import lcd_wr_pkg::*;
#(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned TIME_W = TIME_W_DEF
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_is_data,
   input  logic [DATA_W-1:0] req_data,
   input  logic [TIME_W-1:0] cfg_addr_lead,
   input  logic [TIME_W-1:0] cfg_sel_lead,
   input  logic [TIME_W-1:0] cfg_strobe_len,
   input  logic [TIME_W-1:0] cfg_sel_tail,
   output logic              busy,
   output logic              done,
   output logic              lcd_cs_n,
   output logic              lcd_wr_n,
   output logic              lcd_dc,
   output logic [DATA_W-1:0] lcd_data
);
   localparam int unsigned MAX_PHASE = 1 << TIME_W;

   generate
      if (DATA_W < 1)
         $error("lcd_wr_seq: DATA_W must be at least 1");
      if (TIME_W < 1 || TIME_W > 16)
         $error("lcd_wr_seq: TIME_W must lie in 1..16");
      if (MAX_PHASE < 2)
         $error("lcd_wr_seq: phase range degenerate");
   endgenerate

   seq_state_e        state, state_nxt;
   logic              accept, tmr_load, tmr_expired;
   logic [TIME_W-1:0] tmr_val;
   logic [TIME_W-1:0] sel_lead_q, strobe_len_q, sel_tail_q;
   logic [DATA_W-1:0] word_q;

   assign req_ready = (state == ST_IDLE);
   assign busy      = (state != ST_IDLE);
   assign accept    = req_valid && req_ready;

   always_ff @(posedge clk) begin
      if (rst) begin
         sel_lead_q   <= '0;
         strobe_len_q <= '0;
         sel_tail_q   <= '0;
         word_q       <= '0;
      end else if (accept) begin
         sel_lead_q   <= cfg_sel_lead;
         strobe_len_q <= cfg_strobe_len;
         sel_tail_q   <= cfg_sel_tail;
         word_q       <= req_data;
      end
   end

   lcd_wr_fsm #(.TIME_W(TIME_W)) u_fsm (
      .clk          (clk),
      .rst          (rst),
      .accept       (accept),
      .tmr_expired  (tmr_expired),
      .addr_lead    (cfg_addr_lead),
      .sel_lead_q   (sel_lead_q),
      .strobe_len_q (strobe_len_q),
      .sel_tail_q   (sel_tail_q),
      .state        (state),
      .state_nxt    (state_nxt),
      .tmr_load     (tmr_load),
      .tmr_val      (tmr_val)
   );

   lcd_wr_timer #(.TIME_W(TIME_W)) u_timer (
      .clk      (clk),
      .rst      (rst),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_expired)
   );

   lcd_wr_outreg #(.DATA_W(DATA_W)) u_out (
      .clk         (clk),
      .rst         (rst),
      .state       (state),
      .state_nxt   (state_nxt),
      .accept      (accept),
      .req_is_data (req_is_data),
      .word_q      (word_q),
      .cs_n        (lcd_cs_n),
      .wr_n        (lcd_wr_n),
      .dc          (lcd_dc),
      .data        (lcd_data),
      .done        (done)
   );

   p_accept_blocks_r8: assert property (@(posedge clk) disable iff (rst)
      accept |=> (!req_ready && busy && lcd_cs_n));
   p_dc_held_r2: assert property (@(posedge clk) disable iff (rst)
      (busy && $past(busy)) |-> $stable(lcd_dc));
   p_cs_only_when_busy_r2: assert property (@(posedge clk) disable iff (rst)
      $fell(lcd_cs_n) |-> $past(busy));
endmodule

// File: tb/lcd_wr_seq_test.sv
module lcd_wr_seq_test;
   localparam int DW = 16;
   localparam int TW = 4;
   localparam int WATCHDOG_CYC = 100000;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic          req_is_data = 1'b0;
   logic [DW-1:0] req_data = '0;
   logic [TW-1:0] cfg_addr_lead = '0, cfg_sel_lead = '0;
   logic [TW-1:0] cfg_strobe_len = '0, cfg_sel_tail = '0;
   logic          busy, done, lcd_cs_n, lcd_wr_n, lcd_dc;
   logic [DW-1:0] lcd_data;

   always #10 clk = ~clk;

   lcd_wr_seq #(.DATA_W(DW), .TIME_W(TW)) uut (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
      .req_is_data(req_is_data), .req_data(req_data),
      .cfg_addr_lead(cfg_addr_lead), .cfg_sel_lead(cfg_sel_lead),
      .cfg_strobe_len(cfg_strobe_len), .cfg_sel_tail(cfg_sel_tail),
      .busy(busy), .done(done), .lcd_cs_n(lcd_cs_n), .lcd_wr_n(lcd_wr_n),
      .lcd_dc(lcd_dc), .lcd_data(lcd_data));

   typedef struct {
      bit          dc;
      logic [DW-1:0] data;
      int          a, s, w, h;
   } exp_t;
   exp_t exq[$];

   int checks = 0, failures = 0, sent = 0, completions = 0;
   bit finished = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
      end
   endtask

   // driver: offers a request, waits for acceptance, pushes expected item
   task automatic send(input bit dc, input logic [DW-1:0] d,
                       input int a, input int s, input int w, input int h);
      bit acc;
      exp_t e;
      req_valid      = 1'b1;
      req_is_data    = dc;
      req_data       = d;
      cfg_addr_lead  = TW'(a);
      cfg_sel_lead   = TW'(s);
      cfg_strobe_len = TW'(w);
      cfg_sel_tail   = TW'(h);
      forever begin
         acc = req_ready;
         @(posedge clk);
         if (acc) break;
         #2;
      end
      e.dc = dc; e.data = d; e.a = a + 1; e.s = s + 1; e.w = w + 1; e.h = h + 1;
      exq.push_back(e);
      sent++;
      #2;
      req_valid = 1'b0;
   endtask

   task automatic wait_quiet();
      while (exq.size() != 0) @(posedge clk);
      repeat (3) @(posedge clk);
      #2;
   endtask

   // monitor: follows the bus phase by phase, compares against queue head
   int mph = 0, na = 0, ns = 0, nw = 0, nh = 0;
   logic [DW-1:0] seen;
   always @(negedge clk) begin
      if (rst) begin
         mph = 0;
      end else begin
         case (mph)
            0: begin
               if (done) chk(0, "R9", "done outside end cycle", done, 0);
               if (!lcd_cs_n || !lcd_wr_n) chk(0, "R6", "strobe/select while idle", {lcd_cs_n, lcd_wr_n}, 3);
               if (req_valid && req_ready) begin mph = 1; na = 0; ns = 0; nw = 0; nh = 0; end
            end
            1: begin
               if (lcd_cs_n && lcd_wr_n) begin
                  na++;
                  if (na == 1) begin
                     chk(busy && !req_ready, "R8", "busy/ready in address phase", {busy, req_ready}, 2);
                     if (exq.size() != 0) chk(lcd_dc == exq[0].dc, "R2", "lcd_dc", lcd_dc, exq[0].dc);
                     chk(!done, "R9 R11", "done in address phase", done, 0);
                  end
               end else if (!lcd_cs_n && lcd_wr_n) begin
                  mph = 2; ns = 1;
               end else chk(0, "R6", "strobe before select", lcd_cs_n, 0);
            end
            2: begin
               if (!lcd_cs_n && lcd_wr_n) ns++;
               else if (!lcd_cs_n && !lcd_wr_n) begin
                  mph = 3; nw = 1; seen = lcd_data;
                  if (exq.size() != 0) chk(lcd_data == exq[0].data, "R4", "data at strobe start", lcd_data, exq[0].data);
               end else chk(0, "R5", "select dropped before strobe", lcd_cs_n, 0);
            end
            3: begin
               if (!lcd_cs_n && !lcd_wr_n) begin
                  nw++;
                  if (lcd_data != seen) chk(0, "R7", "data moved in strobe", lcd_data, seen);
               end else if (!lcd_cs_n && lcd_wr_n) begin
                  mph = 4; nh = 1;
               end else chk(0, "R6", "select rose with strobe low", lcd_cs_n, 0);
            end
            default: begin
               if (!lcd_cs_n && lcd_wr_n) nh++;
               else if (lcd_cs_n) begin
                  exp_t e;
                  if (exq.size() == 0) begin
                     chk(0, "R9", "transfer with no request", 1, 0);
                  end else begin
                     e = exq.pop_front();
                     chk(na == e.a, "R2", "address phase length", na, e.a);
                     chk(ns == e.s, "R3", "select lead length", ns, e.s);
                     chk(nw == e.w, "R4", "strobe length", nw, e.w);
                     chk(nh == e.h, "R5", "tail length", nh, e.h);
                     chk(lcd_data == seen && seen == e.data, "R7", "data at deselect", lcd_data, e.data);
                  end
                  chk(done, "R9", "done at deselect", done, 1);
                  chk(req_ready && !busy, "R8", "ready at deselect", {req_ready, busy}, 2);
                  completions++;
                  if (req_valid && req_ready) begin mph = 1; na = 0; ns = 0; nw = 0; nh = 0; end
                  else mph = 0;
               end else chk(0, "R6", "strobe low in tail", lcd_wr_n, 1);
            end
         endcase
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #2;
      chk(lcd_cs_n && lcd_wr_n, "R1", "cs/wr in reset", {lcd_cs_n, lcd_wr_n}, 3);
      chk(lcd_data == 0 && !lcd_dc, "R1", "data/dc in reset", lcd_data, 0);
      chk(req_ready && !busy && !done, "R1", "ready/busy/done in reset", {req_ready, busy, done}, 4);
      rst = 1'b0;
      @(posedge clk); #2;
      chk(lcd_cs_n && lcd_wr_n && lcd_data == 0 && req_ready, "R1", "state after reset", {lcd_cs_n, lcd_wr_n, req_ready}, 7);

      // suggested defaults
      send(1'b0, 16'h002C, lcd_wr_pkg::DEF_ADDR_LEAD, lcd_wr_pkg::DEF_SEL_LEAD,
           lcd_wr_pkg::DEF_STROBE_LEN, lcd_wr_pkg::DEF_SEL_TAIL);
      wait_quiet();
      // shortest: all phases one cycle
      send(1'b1, 16'hA5A5, 0, 0, 0, 0);
      wait_quiet();
      // longest
      send(1'b1, 16'h5A5A, 15, 15, 15, 15);
      wait_quiet();
      // mixed and lopsided
      send(1'b0, 16'h1234, 3, 1, 4, 2);
      wait_quiet();
      send(1'b1, 16'hFFFF, 0, 7, 0, 5);
      wait_quiet();

      // R10: timing inputs changed mid-transfer
      send(1'b1, 16'h0F0F, 2, 3, 1, 4);
      cfg_addr_lead = 4'd15; cfg_sel_lead = 4'd15;
      cfg_strobe_len = 4'd15; cfg_sel_tail = 4'd15;
      wait_quiet();

      // R8: offer while busy with another word, withdraw before end
      send(1'b0, 16'hBEEF, 6, 6, 6, 6);
      repeat (4) @(posedge clk);
      #2;
      req_valid = 1'b1; req_data = 16'hDEAD; req_is_data = 1'b1;
      repeat (5) begin
         chk(!req_ready, "R8", "ready while busy", req_ready, 0);
         @(posedge clk); #2;
      end
      req_valid = 1'b0;
      wait_quiet();
      chk(completions == sent, "R8", "transfers vs requests", completions, sent);

      // R11: back-to-back requests in done cycle, flag toggling
      send(1'b0, 16'h0001, 1, 0, 2, 0);
      send(1'b1, 16'h0002, 0, 2, 0, 1);
      send(1'b0, 16'h0003, 4, 0, 1, 3);
      wait_quiet();
      chk(completions == sent, "R11", "back-to-back completions", completions, sent);
      chk(mph == 0 && lcd_cs_n && !busy, "R9", "idle at end", mph, 0);

      if (!finished) begin
         finished = 1;
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (WATCHDOG_CYC) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++;
         failures++;
         $display("FAIL watchdog expired, run hung actual=0 expected=1");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule